// File: doc/BRIEF.md
# Phase-Accumulator Oscillator with Selectable Pin Outputs

The block is a numerically controlled oscillator. A 32-bit phase accumulator adds a frequency word on every system clock, wrapping modulo 2^32. Its most significant bit is a square wave at a frequency of frq / 2^32 times the clock frequency. A single 32-bit control word picks the operating mode and chooses which of 32 output pins carry that wave. The block produces a 32-bit pin value vector and a matching output-enable vector. A pin whose enable is low is free for other logic in the chip to use.

Three write ports load the control, frequency and phase words. In single-ended mode the wave appears on one chosen pin. In differential mode the wave appears on one pin and its inverse on a second pin. Every other mode code turns the counter's pin outputs off. The accumulator keeps running whatever the mode is, so a mode change never resets the phase.

Top module: `nco_pin_counter`

## Requirements
- R1: While `rst` is high at a clock edge, the control, frequency and phase registers clear to zero. `pin_out` and `pin_oe` are zero after that edge.
- R2: At each clock edge without a phase write, the accumulator becomes its old value plus the frequency register's old value, modulo 2^32. A frequency write takes effect on the edge that follows it.
- R3: At a clock edge with `phs_we` high, the accumulator loads `phs_wdata` in place of the addition.
- R4: The mode field is control bits 30..26. Mode 5'b00100 is single-ended. The pin indexed by control bits 4..0 carries accumulator bit 31, and only that pin is enabled. The second-pin field has no effect in this mode.
- R5: Mode 5'b00101 is differential. The pin indexed by bits 4..0 carries accumulator bit 31. The pin indexed by bits 13..9 carries its inverse. Both pins are enabled.
- R6: Control bits 25..23, bit 5, bit 14 and bit 31 have no effect in either oscillator mode. Any value there gives identical outputs.
- R7: Any mode code other than 5'b00100 and 5'b00101, including 5'b00000, drives `pin_oe` and `pin_out` to all zeros.
- R8: The outputs are registered. After each edge they reflect the accumulator and control values held before that edge. A control write never disturbs the accumulator.
- R9: In differential mode with both pin indices equal, that pin carries the non-inverted bit 31 and is the only pin enabled.
- R10: Every pin whose enable is low has a pin value of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control word: mode, pin indices, divider tap |
| frq_we | input | 1 | Frequency word write strobe |
| frq_wdata | input | 32 | Frequency word added each clock |
| phs_we | input | 1 | Phase word write strobe |
| phs_wdata | input | 32 | Value loaded into the accumulator |
| pin_out | output | 32 | Registered pin values |
| pin_oe | output | 32 | Registered pin output enables |

## Verification
The hardest case to reach is the exact clock where the accumulator carries into bit 31 or wraps past 2^32. At typical frequency words this takes billions of clocks. The stimulus reaches it in a few cycles by loading the phase register just below the boundary, at 0x7FFFFFFF and 0xFFFFFFFF, with a frequency word of 1. A frequency word of 2^31 then makes bit 31 toggle on every edge. Each cycle of a mode change or a pin swap is therefore visible at the pins.

// File: rtl/nco_pkg.sv
package nco_pkg;
  localparam int CTRL_W   = 32;
  localparam int MODE_LSB = 26;
  localparam int MODE_W   = 5;
  localparam int APIN_LSB = 0;
  localparam int BPIN_LSB = 9;

  localparam logic [MODE_W-1:0] CODE_SINGLE = 5'b00100;
  localparam logic [MODE_W-1:0] CODE_DIFF   = 5'b00101;

  typedef enum logic [1:0] {
    OSC_OFF    = 2'd0,
    OSC_SINGLE = 2'd1,
    OSC_DIFF   = 2'd2
  } osc_mode_e;
endpackage

// File: rtl/nco_ctrl_decode.sv
module nco_ctrl_decode
  import nco_pkg::*;
#(
  parameter int PINS  = 32,
  parameter int IDX_W = $clog2(PINS)
) (
  input  logic [CTRL_W-1:0] ctrl,
  output osc_mode_e         mode,
  output logic [IDX_W-1:0]  a_idx,
  output logic [IDX_W-1:0]  b_idx
);
  logic [MODE_W-1:0] code;

  always_comb begin
    code  = ctrl[MODE_LSB +: MODE_W];
    a_idx = ctrl[APIN_LSB +: IDX_W];
    b_idx = ctrl[BPIN_LSB +: IDX_W];
    unique case (code)
      CODE_SINGLE: mode = OSC_SINGLE;
      CODE_DIFF:   mode = OSC_DIFF;
      default:     mode = OSC_OFF;
    endcase
  end
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] frq,
  input  logic             load,
  input  logic [ACC_W-1:0] load_val,
  output logic [ACC_W-1:0] acc
);
  always_ff @(posedge clk) begin
    if (rst)       acc <= '0;
    else if (load) acc <= load_val;
    else           acc <= acc + frq;
  end

  AST_ACC_STEP: assert property (@(posedge clk) disable iff (rst)
    !load |=> acc == $past(acc) + $past(frq)); // R2
  AST_PHASE_LOAD: assert property (@(posedge clk) disable iff (rst)
    load |=> acc == $past(load_val)); // R3
endmodule

// File: rtl/nco_pin_router.sv
module nco_pin_router
  import nco_pkg::*;
#(
  parameter int PINS  = 32,
  parameter int IDX_W = $clog2(PINS)
) (
  input  logic             clk,
  input  logic             rst,
  input  osc_mode_e        mode,
  input  logic [IDX_W-1:0] a_idx,
  input  logic [IDX_W-1:0] b_idx,
  input  logic             wave,
  output logic [PINS-1:0]  pin_out,
  output logic [PINS-1:0]  pin_oe
);
  logic [PINS-1:0] nxt_out, nxt_oe;

  for (genvar g = 0; g < PINS; g++) begin : g_pin
    logic hit_a, hit_b;
    always_comb begin
      hit_a = (mode != OSC_OFF) && (a_idx == IDX_W'(g));
      hit_b = (mode == OSC_DIFF) && (b_idx == IDX_W'(g)) && !hit_a;
      nxt_oe[g]  = hit_a | hit_b;
      nxt_out[g] = hit_a ? wave : (hit_b ? ~wave : 1'b0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_out <= '0;
      pin_oe  <= '0;
    end else begin
      pin_out <= nxt_out;
      pin_oe  <= nxt_oe;
    end
  end

  AST_UNDRIVEN_LOW: assert property (@(posedge clk) disable iff (rst)
    (pin_out & ~pin_oe) == '0); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    mode == OSC_OFF |=> pin_oe == '0); // R7
  AST_SINGLE_ONE_PIN: assert property (@(posedge clk) disable iff (rst)
    mode == OSC_SINGLE |=> $countones(pin_oe) == 1); // R4
  AST_DIFF_TWO_PINS: assert property (@(posedge clk) disable iff (rst)
    (mode == OSC_DIFF && a_idx != b_idx) |=> $countones(pin_oe) == 2); // R5
  AST_DIFF_SHARED: assert property (@(posedge clk) disable iff (rst)
    (mode == OSC_DIFF && a_idx == b_idx) |=> $countones(pin_oe) == 1); // R9
  AST_A_FOLLOWS_WAVE: assert property (@(posedge clk) disable iff (rst)
    mode != OSC_OFF |=> pin_out[$past(a_idx)] == $past(wave)); // R8
endmodule

// File: rtl/nco_pin_counter.sv
module nco_pin_counter
  import nco_pkg::*;
#(
  parameter int PINS  = 32,
  parameter int ACC_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  input  logic              frq_we,
  input  logic [ACC_W-1:0]  frq_wdata,
  input  logic              phs_we,
  input  logic [ACC_W-1:0]  phs_wdata,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   pin_oe
);
  localparam int IDX_W = $clog2(PINS);

  logic [CTRL_W-1:0] ctrl_q;
  logic [ACC_W-1:0]  frq_q;
  logic [ACC_W-1:0]  acc;
  osc_mode_e         mode;
  logic [IDX_W-1:0]  a_idx, b_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      frq_q  <= '0;
    end else begin
      if (ctrl_we) ctrl_q <= ctrl_wdata;
      if (frq_we)  frq_q  <= frq_wdata;
    end
  end

  nco_ctrl_decode #(.PINS(PINS), .IDX_W(IDX_W)) u_dec (
    .ctrl(ctrl_q), .mode(mode), .a_idx(a_idx), .b_idx(b_idx)
  );

  nco_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst(rst), .frq(frq_q), .load(phs_we),
    .load_val(phs_wdata), .acc(acc)
  );

  nco_pin_router #(.PINS(PINS), .IDX_W(IDX_W)) u_route (
    .clk(clk), .rst(rst), .mode(mode), .a_idx(a_idx), .b_idx(b_idx),
    .wave(acc[ACC_W-1]), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  AST_CTRL_KEEPS_PHASE: assert property (@(posedge clk) disable iff (rst)
    (ctrl_we && !phs_we) |=> acc == $past(acc) + $past(frq_q)); // R8
endmodule

// File: tb/nco_pin_counter_test.sv
module nco_pin_counter_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        ctrl_we, frq_we, phs_we;
  logic [31:0] ctrl_wdata, frq_wdata, phs_wdata;
  logic [31:0] pin_out, pin_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [31:0] m_acc, m_ctrl, m_frq, exp_out, exp_oe;

  always #5 clk = ~clk;

  nco_pin_counter uut (
    .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .frq_we(frq_we), .frq_wdata(frq_wdata), .phs_we(phs_we),
    .phs_wdata(phs_wdata), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  function automatic logic [31:0] cw(input logic [4:0] md, input logic [5:0] a,
                                     input logic [5:0] b, input logic [2:0] dv);
    return {1'b0, md, dv, 8'h00, b, 3'b000, a};
  endfunction

  task automatic route(input logic [31:0] acc, input logic [31:0] c);
    logic [4:0] md;
    int pa, pb;
    md = c[30:26];
    pa = int'(c[4:0]);
    pb = int'(c[13:9]);
    exp_out = '0;
    exp_oe  = '0;
    if (md == 5'b00101) begin
      exp_oe[pb]  = 1'b1;
      exp_out[pb] = ~acc[31];
    end
    if (md == 5'b00100 || md == 5'b00101) begin
      exp_oe[pa]  = 1'b1;
      exp_out[pa] = acc[31];
    end
  endtask

  task automatic step(input logic cwe, input logic [31:0] cd, input logic fwe,
                      input logic [31:0] fd, input logic pwe, input logic [31:0] pd);
    ctrl_we = cwe; ctrl_wdata = cd;
    frq_we  = fwe; frq_wdata  = fd;
    phs_we  = pwe; phs_wdata  = pd;
    @(posedge clk);
    route(m_acc, m_ctrl);
    m_acc = pwe ? pd : m_acc + m_frq;
    if (cwe) m_ctrl = cd;
    if (fwe) m_frq = fd;
    @(negedge clk);
    ctrl_we = 0; frq_we = 0; phs_we = 0;
  endtask

  task automatic idle(); step(0, 0, 0, 0, 0, 0); endtask

  task automatic check(input string tag);
    checks++;
    if (pin_out !== exp_out || pin_oe !== exp_oe) begin
      fails++;
      $display("FAIL %s: out=%h oe=%h expected out=%h oe=%h",
               tag, pin_out, pin_oe, exp_out, exp_oe);
    end
  endtask

  task automatic t_reset();
    rst = 1;
    ctrl_we = 0; frq_we = 0; phs_we = 0;
    ctrl_wdata = 0; frq_wdata = 0; phs_wdata = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    m_acc = 0; m_ctrl = 0; m_frq = 0; exp_out = 0; exp_oe = 0;
    check("R1 reset state");
    rst = 0;
    idle();
    check("R1 idle after reset");
  endtask

  task automatic t_single();
    step(0, 0, 1, 32'h8000_0000, 1, 0);
    step(1, cw(5'b00100, 6'd3, 6'd7, 3'd0), 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) begin
      idle();
      check("R4 R2 single-ended toggle");
    end
  endtask

  task automatic t_diff();
    step(1, cw(5'b00101, 6'd10, 6'd20, 3'd0), 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) begin
      idle();
      check("R5 R10 differential pair");
    end
  endtask

  task automatic t_ignored();
    step(1, cw(5'b00100, 6'd3, 6'd7, 3'd0), 0, 0, 0, 0);
    idle();
    check("R6 baseline");
    step(1, cw(5'b00100, 6'h23, 6'h3F, 3'd7) | 32'h8000_4000, 0, 0, 0, 0);
    idle();
    check("R6 single ignored fields");
    step(1, cw(5'b00101, 6'h2A, 6'h34, 3'd5) | 32'h8000_0000, 0, 0, 0, 0);
    idle();
    check("R6 differential ignored fields");
  endtask

  task automatic t_off();
    step(1, cw(5'b00000, 6'd3, 6'd7, 3'd0), 0, 0, 0, 0);
    idle();
    check("R7 mode zero");
    step(1, cw(5'b00110, 6'd1, 6'd2, 3'd0), 0, 0, 0, 0);
    idle();
    check("R7 mode 00110");
    step(1, cw(5'b11111, 6'd1, 6'd2, 3'd1), 0, 0, 0, 0);
    idle();
    check("R7 mode 11111");
  endtask

  task automatic t_phase();
    step(1, cw(5'b00100, 6'd31, 6'd0, 3'd0), 1, 32'd1, 1, 32'h7FFF_FFFF);
    check("R3 load cycle");
    idle();
    check("R3 loaded value below boundary");
    idle();
    check("R2 carry into bit 31");
    step(0, 0, 0, 0, 1, 32'hFFFF_FFFF);
    idle();
    check("R3 loaded all ones");
    idle();
    check("R2 wrap modulo 2^32");
  endtask

  task automatic t_ctrl_keep();
    step(0, 0, 1, 32'h4000_0000, 1, 0);
    idle();
    step(1, cw(5'b00101, 6'd0, 6'd1, 3'd0), 0, 0, 0, 0);
    check("R8 change on edge");
    step(1, cw(5'b00100, 6'd8, 6'd0, 3'd0), 0, 0, 0, 0);
    check("R8 control switch keeps phase");
    step(1, cw(5'b00000, 6'd8, 6'd0, 3'd0), 0, 0, 0, 0);
    check("R8 one-cycle lag");
    step(1, cw(5'b00100, 6'd8, 6'd0, 3'd0), 0, 0, 0, 0);
    check("R8 off then back");
    for (int i = 0; i < 3; i++) begin
      idle();
      check("R8 phase continuity");
    end
  endtask

  task automatic t_shared();
    step(0, 0, 1, 32'h8000_0000, 0, 0);
    step(1, cw(5'b00101, 6'd12, 6'd12, 3'd0), 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) begin
      idle();
      check("R9 equal pin indices");
    end
  endtask

  initial begin
    t_reset();
    t_single();
    t_diff();
    t_ignored();
    t_off();
    t_phase();
    t_ctrl_keep();
    t_shared();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule